// File: doc/BRIEF.md
# Receive FIFO with Output Prefetch Pipeline

This block is a synchronous receive queue for 32-bit long-words. A producer writes words through a write port that has a full flag. A consumer reads through a port that shows the oldest word with a valid flag and takes it with a pop strobe. The read side sits behind a four-stage prefetch pipeline. A new word goes into that pipeline first. A word is kept in the main storage array only when the pipeline is already occupied.

Because of this, the block has two separate status bits. The "storage empty" bit describes only the storage array. The "data valid" bit is high whenever a word can be read. Software can therefore see up to four words waiting in the pipeline while the array reports empty. When a pop frees a pipeline stage, the array refills that stage. Words always leave in the order they arrived. The total capacity is the array depth plus four.

Top module: `rxq_prefetch_fifo`

## Requirements
- R1: `full` is 1 exactly when the block holds ARRAY_DEPTH+4 words (12 with ARRAY_DEPTH=8), and 0 whenever at least one more word fits.
- R2: Words leave in arrival order. `rd_data` shows the oldest held word while `rd_valid` is 1. A pop (`rd_pop`=1 while `rd_valid`=1) removes that word at the clock edge.
- R3: A write while `full` is 1 is dropped. The dropped word never appears at the output, and `overflow` becomes 1 on the next cycle and stays 1 until reset.
- R4: `rd_valid` is 1 whenever the block holds at least one word, including words held only in the pipeline. A word written into an empty block is readable on the cycle after the write edge.
- R5: `store_empty` is 1 while the block holds four or fewer words and is idle, and `rd_valid` is 1 at the same time whenever at least one word is held.
- R6: The pipeline fills first. After four writes into an empty block, `store_empty` stays 1. A fifth write clears it on the next cycle.
- R7: A pop while `rd_valid` is 0 changes no state. While `rd_valid` is 0, `rd_data` holds the most recently popped word (0 after reset).
- R8: A stage freed by a pop is refilled from the array. Pops on consecutive cycles each return the next word, and `rd_valid` does not drop while words remain.
- R9: A synchronous active-high `rst` empties the pipeline and the array. On the cycle after reset, `rd_valid`=0, `store_empty`=1, `full`=0, `overflow`=0 and `rd_data`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Word to write |
| full | output | 1 | No room for another word |
| rd_pop | input | 1 | Take the head word |
| rd_data | output | 32 | Head word, or last popped word when not valid |
| rd_valid | output | 1 | A word is available to read |
| store_empty | output | 1 | Storage array holds no word |
| overflow | output | 1 | Sticky: a write was dropped while full |

## Verification
The assertions assume that `wr_en` and `rd_pop` are ordinary one-bit strobes that hold steady through each clock edge. They also assume the design may legally receive a pop while nothing is valid or a write while full, so these are treated as defined cases and not as illegal input. The stimulus changes every input shortly after a rising edge and keeps it constant until the next edge. It deliberately includes pops on an empty block and writes past capacity, so the properties on ignored pops and sticky overflow are exercised and not left vacuous.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    localparam int WORD_W      = 32;
    localparam int PIPE_STAGES = 4;

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        logic  vld;
        word_t data;
    } stage_t;

    function automatic int total_capacity(input int array_depth);
        return array_depth + PIPE_STAGES;
    endfunction
endpackage

// File: rtl/rxq_store_array.sv
module rxq_store_array
    import rxq_pkg::*;
#(
    parameter int DEPTH = 512
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       push,
    input  word_t                      push_data,
    input  logic                       pop,
    output word_t                      head,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH+1);

    word_t         mem [DEPTH];
    logic [AW-1:0] wptr, rptr;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    assign head = mem[rptr];

    always_ff @(posedge clk) begin
        if (push) mem[wptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push) wptr <= bump(wptr);
            if (pop)  rptr <= bump(rptr);
            case ({push, pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/rxq_prefetch_pipe.sv
module rxq_prefetch_pipe
    import rxq_pkg::*;
#(
    parameter int STAGES = PIPE_STAGES
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        pop,
    input  logic                        ins,
    input  word_t                       ins_data,
    output logic                        head_valid,
    output word_t                       head_data,
    output logic [$clog2(STAGES+1)-1:0] count
);
    localparam int PCW = $clog2(STAGES+1);

    stage_t         cur [STAGES];
    stage_t         nxt [STAGES];
    logic [PCW-1:0] slot;

    assign slot       = count - PCW'(pop);
    assign head_valid = cur[0].vld;
    assign head_data  = cur[0].data;

    always_comb begin
        for (int i = 0; i < STAGES; i++) begin
            if (pop) nxt[i] = (i < STAGES-1) ? cur[i+1] : '0;
            else     nxt[i] = cur[i];
            if (ins && slot == PCW'(i)) nxt[i] = '{vld: 1'b1, data: ins_data};
        end
    end

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) cur[g] <= '0;
            else     cur[g] <= nxt[g];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) count <= '0;
        else     count <= slot + PCW'(ins);
    end
endmodule

// File: rtl/rxq_prefetch_fifo.sv
module rxq_prefetch_fifo
    import rxq_pkg::*;
#(
    parameter int ARRAY_DEPTH = 512
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output logic        full,
    input  logic        rd_pop,
    output logic [31:0] rd_data,
    output logic        rd_valid,
    output logic        store_empty,
    output logic        overflow
);
    localparam int ACW = $clog2(ARRAY_DEPTH+1);
    localparam int PCW = $clog2(PIPE_STAGES+1);

    logic [ACW-1:0] arr_cnt;
    logic [PCW-1:0] pipe_cnt;
    word_t          arr_head, pipe_head, last_word, ins_data;
    logic           pipe_valid, pop_ok, wr_ok, room, xfer, ins, arr_push;

    assign full     = (arr_cnt == ACW'(ARRAY_DEPTH)) && (pipe_cnt == PCW'(PIPE_STAGES));
    assign pop_ok   = rd_pop && pipe_valid;
    assign wr_ok    = wr_en && !full;
    assign room     = (pipe_cnt - PCW'(pop_ok)) < PCW'(PIPE_STAGES);
    assign xfer     = (arr_cnt != '0) && room;
    assign ins      = xfer || (wr_ok && arr_cnt == '0 && room);
    assign ins_data = xfer ? arr_head : wr_data;
    assign arr_push = wr_ok && !(arr_cnt == '0 && room);

    rxq_store_array #(.DEPTH(ARRAY_DEPTH)) u_array (
        .clk(clk), .rst(rst),
        .push(arr_push), .push_data(wr_data),
        .pop(xfer), .head(arr_head), .count(arr_cnt)
    );

    rxq_prefetch_pipe #(.STAGES(PIPE_STAGES)) u_pipe (
        .clk(clk), .rst(rst),
        .pop(pop_ok), .ins(ins), .ins_data(ins_data),
        .head_valid(pipe_valid), .head_data(pipe_head), .count(pipe_cnt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            last_word <= '0;
            overflow  <= 1'b0;
        end else begin
            if (pop_ok)          last_word <= pipe_head;
            if (wr_en && full)   overflow  <= 1'b1;
        end
    end

    assign rd_valid    = pipe_valid;
    assign rd_data     = pipe_valid ? pipe_head : last_word;
    assign store_empty = (arr_cnt == '0);
endmodule

// File: rtl/rxq_prefetch_fifo_chk.sv
module rxq_prefetch_fifo_chk (
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic        rd_pop,
    input logic        full,
    input logic [31:0] rd_data,
    input logic        rd_valid,
    input logic        store_empty,
    input logic        overflow
);
    AST_DROP_SETS_OVF: assert property (@(posedge clk) disable iff (rst)
        (wr_en && full) |=> overflow);                                   // R3
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);                                          // R3
    AST_STORE_IMPLIES_VALID: assert property (@(posedge clk) disable iff (rst)
        !store_empty |-> rd_valid);                                      // R4
    AST_FULL_HAS_DATA: assert property (@(posedge clk) disable iff (rst)
        full |-> (rd_valid && !store_empty));                            // R1
    AST_IDLE_POP_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (rd_pop && !rd_valid && !wr_en) |=> ($stable(rd_data) && !rd_valid)); // R7
    AST_RESET_FLUSH: assert property (@(posedge clk)
        $past(rst) |-> (!rd_valid && store_empty && !full && !overflow && rd_data == '0)); // R9
endmodule

bind rxq_prefetch_fifo rxq_prefetch_fifo_chk u_chk (.*);

// File: tb/rxq_prefetch_fifo_bench.sv
`timescale 1ns/1ps
module rxq_prefetch_fifo_bench;
    localparam int DEPTH = 8;
    localparam int CAP   = DEPTH + 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0, rd_pop = 1'b0;
    logic [31:0] wr_data = '0;
    logic        full, rd_valid, store_empty, overflow;
    logic [31:0] rd_data;

    int tests = 0, fails = 0;
    logic [31:0] model[$];
    logic [31:0] last_pop = '0;
    logic        exp_ovf = 1'b0;
    logic        mon_on = 1'b0;

    always #4 clk = ~clk;

    rxq_prefetch_fifo #(.ARRAY_DEPTH(DEPTH)) u_rxq_prefetch_fifo (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .full(full),
        .rd_pop(rd_pop), .rd_data(rd_data), .rd_valid(rd_valid),
        .store_empty(store_empty), .overflow(overflow)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input logic we, input logic [31:0] d, input logic pop);
        @(posedge clk); #2;
        wr_en = we; wr_data = d; rd_pop = pop;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, '0, 1'b0);
    endtask

    // Monitor / scoreboard: inputs are steady at the falling edge.
    always @(negedge clk) begin
        if (mon_on && !rst) begin
            check("R4 rd_valid", rd_valid, model.size() > 0);
            check("R1 full", full, model.size() == CAP);
            check("R3 overflow", overflow, exp_ovf);
            if (!rd_valid) check("R7 rd_data hold", rd_data, last_pop);
            if (wr_en) begin
                if (model.size() < CAP) model.push_back(wr_data);
                else exp_ovf = 1'b1;
            end
            if (rd_pop && model.size() > 0 && rd_valid) begin
                check("R2 order", rd_data, model[0]);
                last_pop = model[0];
                void'(model.pop_front());
            end
        end
    end

    initial begin
        #(8 * 100000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        idle(3);
        @(posedge clk); #2 rst = 1'b0;
        @(negedge clk);
        check("R9 valid after reset", rd_valid, 1'b0);
        check("R9 store_empty after reset", store_empty, 1'b1);
        check("R9 rd_data after reset", rd_data, 32'h0);
        check("R9 full after reset", full, 1'b0);
        mon_on = 1'b1;

        // R7: pops on an empty block
        cyc(1'b0, '0, 1'b1); cyc(1'b0, '0, 1'b1);
        idle(1);
        @(negedge clk) check("R7 empty pop", rd_data, 32'h0);

        // R6 / R5: four words stay in the pipeline
        for (int i = 0; i < 4; i++) cyc(1'b1, 32'hA000_0000 + i, 1'b0);
        idle(2);
        @(negedge clk);
        check("R5 store_empty with 4", store_empty, 1'b1);
        check("R5 valid with 4", rd_valid, 1'b1);
        cyc(1'b1, 32'hA000_0004, 1'b0);
        idle(1);
        @(negedge clk) check("R6 fifth word to array", store_empty, 1'b0);

        // R8 / R2: back-to-back pops drain in order
        for (int i = 0; i < 7; i++) cyc(1'b0, '0, 1'b1);
        idle(2);
        @(negedge clk) check("R7 last popped", rd_data, 32'hA000_0004);

        // R1 / R3: fill past capacity
        for (int i = 0; i < CAP + 2; i++) cyc(1'b1, 32'hB000_0000 + i, 1'b0);
        idle(2);
        @(negedge clk) check("R1 full at capacity", full, 1'b1);
        for (int i = 0; i < CAP; i++) cyc(1'b0, '0, 1'b1);
        idle(2);
        @(negedge clk);
        check("R3 dropped not seen", rd_valid, 1'b0);
        check("R3 overflow sticky", overflow, 1'b1);

        // Concurrent traffic with a ragged pop pattern
        for (int i = 0; i < 60; i++)
            cyc(i % 3 != 2, 32'hC000_0000 + i, (i % 4) != 0);
        for (int i = 0; i < 20; i++) cyc(1'b0, '0, 1'b1);
        idle(2);

        // R9: reset with data held
        for (int i = 0; i < 7; i++) cyc(1'b1, 32'hD000_0000 + i, 1'b0);
        @(posedge clk); #2;
        wr_en = 1'b0; mon_on = 1'b0; rst = 1'b1;
        @(posedge clk); #2 rst = 1'b0;
        model.delete(); last_pop = '0; exp_ovf = 1'b0;
        @(negedge clk);
        check("R9 flush valid", rd_valid, 1'b0);
        check("R9 flush store", store_empty, 1'b1);
        check("R9 flush overflow", overflow, 1'b0);
        mon_on = 1'b1;
        cyc(1'b1, 32'hE000_0001, 1'b0);
        idle(1);
        @(negedge clk) check("R4 one-cycle visibility", rd_data, 32'hE000_0001);
        cyc(1'b0, '0, 1'b1);
        idle(3);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule